// File: doc/BRIEF.md
# Two-Step Flash Conversion Sequencer

This block is the digital timing and encoding core of an 8-bit converter that resolves its result in two 4-bit flash steps. A one-cycle start request opens a track window of programmable length. At its end the coarse comparator bank is sampled and encoded into the upper nibble. That nibble is placed in the result register at once and is also driven out as the 4-bit code of an external DAC. The DAC generates the residue that the fine comparator bank resolves.

A second programmable window follows. At its end the fine bank is sampled and encoded into the lower nibble, and a one-cycle completion pulse is raised. Both comparator banks arrive as 15-bit thermometer buses. The analog parts (comparators, ladder and DAC) sit outside the block. The result register keeps its contents between conversions, so the last value can be read at any time.

Top module: `twostep_flash_seq`

## Requirements
- R1: After reset, `result_o`, `dac_code_o`, `upper_valid_o` and `done_o` are all zero.
- R2: A 15-bit comparator bus encodes to one plus the index of its highest set bit, where bit 0 is the lowest comparator and a set bit above a cleared one (a bubble) does not stop the search. An all-zero bus encodes to 0 and an all-ones bus encodes to 15.
- R3: The start request is sampled on a clock edge. Exactly TRACK_CYC clock edges after the edge that accepts it, `dac_code_o` and `result_o[7:4]` take the encoded coarse bus, and `upper_valid_o` rises.
- R4: `dac_code_o` changes only on a coarse-latch edge and otherwise holds its value.
- R5: Exactly FINE_CYC edges after the coarse-latch edge, `result_o[3:0]` takes the encoded fine bus and `done_o` is high for exactly one cycle.
- R6: `result_o[3:0]` keeps the previous conversion's lower nibble until the fine-latch edge. Between the two latches the result is therefore {new upper nibble, old lower nibble}.
- R7: A start request while a conversion is in progress is ignored and does not disturb the timing. A start request is accepted in any idle cycle, including the cycle in which `done_o` is high.
- R8: `upper_valid_o` stays high from the coarse-latch edge until the edge that accepts the next start request, where it clears.
- R9: Each comparator bus is sampled only on its own latch edge. Its value in any other cycle has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Conversion start request |
| coarse_therm_i | input | 15 | Coarse comparator bank, thermometer code |
| fine_therm_i | input | 15 | Fine comparator bank, thermometer code |
| dac_code_o | output | 4 | Upper nibble driven to the residue DAC |
| result_o | output | 8 | Conversion result register |
| upper_valid_o | output | 1 | Upper nibble of the current conversion is present |
| done_o | output | 1 | One-cycle pulse when the conversion completes |

## Verification
Let the edge that accepts a start request be edge k. The coarse results are due just after edge k+TRACK_CYC, and the lower nibble and completion pulse are due just after edge k+TRACK_CYC+FINE_CYC. The pulse must be gone one edge later. The bench counts falling edges from the one where it raises the start request. It drives each valid comparator value only in the single cycle before its latch edge, and drives random values on the buses in every other cycle. It samples the outputs on the falling edge just before and just after each latch edge. An early, late or restarted phase, or a bus sampled at the wrong time, therefore shows up as a mismatch. Requests made while a conversion is busy, and back-to-back starts in the completion cycle, are mixed into the same timeline.

// File: rtl/tsf_pkg.sv
`timescale 1ns/1ps
package tsf_pkg;
  localparam int NIB_W   = 4;
  localparam int THERM_W = (1 << NIB_W) - 1;
  localparam int RES_W   = 2 * NIB_W;

  typedef enum logic [1:0] {PH_IDLE, PH_TRACK, PH_FINE} phase_t;

  // Code = 1 + index of the highest set comparator; 0 when none set.
  function automatic logic [NIB_W-1:0] therm_to_code(input logic [THERM_W-1:0] t);
    logic [NIB_W-1:0] c;
    c = '0;
    for (int i = 0; i < THERM_W; i++) begin
      if (t[i]) c = NIB_W'(i + 1);
    end
    return c;
  endfunction
endpackage

// File: rtl/tsf_therm_enc.sv
`timescale 1ns/1ps
module tsf_therm_enc
  import tsf_pkg::*;
(
  input  logic [THERM_W-1:0] therm,
  output logic [NIB_W-1:0]   code
);
  assign code = therm_to_code(therm);
endmodule

// File: rtl/tsf_phase_ctrl.sv
`timescale 1ns/1ps
module tsf_phase_ctrl
  import tsf_pkg::*;
#(
  parameter int TRACK_CYC = 100,
  parameter int FINE_CYC  = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic start_acc,
  output logic coarse_latch,
  output logic fine_latch
);
  localparam int MAX_CYC = (TRACK_CYC > FINE_CYC) ? TRACK_CYC : FINE_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] TRACK_LAST = CNT_W'(TRACK_CYC - 1);
  localparam logic [CNT_W-1:0] FINE_LAST  = CNT_W'(FINE_CYC - 1);

  phase_t           ph;
  logic [CNT_W-1:0] ctr;

  assign start_acc    = (ph == PH_IDLE) && start;
  assign coarse_latch = (ph == PH_TRACK) && (ctr == TRACK_LAST);
  assign fine_latch   = (ph == PH_FINE) && (ctr == FINE_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph  <= PH_IDLE;
      ctr <= '0;
    end else begin
      case (ph)
        PH_IDLE: begin
          if (start) begin
            ph  <= PH_TRACK;
            ctr <= '0;
          end
        end
        PH_TRACK: begin
          if (coarse_latch) begin
            ph  <= PH_FINE;
            ctr <= '0;
          end else begin
            ctr <= ctr + 1'b1;
          end
        end
        PH_FINE: begin
          if (fine_latch) ph <= PH_IDLE;
          else            ctr <= ctr + 1'b1;
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tsf_result_reg.sv
`timescale 1ns/1ps
module tsf_result_reg
  import tsf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_acc,
  input  logic             coarse_latch,
  input  logic             fine_latch,
  input  logic [NIB_W-1:0] upper_code,
  input  logic [NIB_W-1:0] lower_code,
  output logic [NIB_W-1:0] dac_code,
  output logic [RES_W-1:0] result,
  output logic             upper_valid,
  output logic             done
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_code    <= '0;
      result      <= '0;
      upper_valid <= 1'b0;
      done        <= 1'b0;
    end else begin
      done <= fine_latch;
      if (start_acc) upper_valid <= 1'b0;
      if (coarse_latch) begin
        dac_code              <= upper_code;
        result[RES_W-1:NIB_W] <= upper_code;
        upper_valid           <= 1'b1;
      end
      if (fine_latch) result[NIB_W-1:0] <= lower_code;
    end
  end
endmodule

// File: rtl/twostep_flash_seq.sv
`timescale 1ns/1ps
module twostep_flash_seq
  import tsf_pkg::*;
#(
  parameter int TRACK_CYC = 100,
  parameter int FINE_CYC  = 60
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [THERM_W-1:0] coarse_therm_i,
  input  logic [THERM_W-1:0] fine_therm_i,
  output logic [NIB_W-1:0]   dac_code_o,
  output logic [RES_W-1:0]   result_o,
  output logic               upper_valid_o,
  output logic               done_o
);
  // Named internal events, also observed by the bound checker.
  logic             start_acc;
  logic             coarse_latch;
  logic             fine_latch;
  logic [NIB_W-1:0] upper_code;
  logic [NIB_W-1:0] lower_code;

  tsf_phase_ctrl #(.TRACK_CYC(TRACK_CYC), .FINE_CYC(FINE_CYC)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start_i),
    .start_acc(start_acc), .coarse_latch(coarse_latch), .fine_latch(fine_latch)
  );

  tsf_therm_enc u_enc_coarse (.therm(coarse_therm_i), .code(upper_code));
  tsf_therm_enc u_enc_fine   (.therm(fine_therm_i),   .code(lower_code));

  tsf_result_reg u_res (
    .clk(clk), .rst_n(rst_n),
    .start_acc(start_acc), .coarse_latch(coarse_latch), .fine_latch(fine_latch),
    .upper_code(upper_code), .lower_code(lower_code),
    .dac_code(dac_code_o), .result(result_o),
    .upper_valid(upper_valid_o), .done(done_o)
  );
endmodule

// File: rtl/tsf_seq_chk.sv
`timescale 1ns/1ps
module tsf_seq_chk
  import tsf_pkg::*;
#(
  parameter int TRACK_CYC = 100,
  parameter int FINE_CYC  = 60
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_acc,
  input logic             coarse_latch,
  input logic             fine_latch,
  input logic [NIB_W-1:0] dac_code,
  input logic [RES_W-1:0] result,
  input logic             upper_valid,
  input logic             done
);
  logic [15:0] gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         gap <= '0;
    else if (start_acc || coarse_latch) gap <= '0;
    else                                gap <= gap + 1'b1;
  end

  p_track_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    coarse_latch |-> gap == 16'(TRACK_CYC - 1));
  p_upper_dac_r3: assert property (@(posedge clk) disable iff (!rst_n)
    upper_valid |-> result[RES_W-1:NIB_W] == dac_code);
  p_dac_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !coarse_latch |=> $stable(dac_code));
  p_fine_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fine_latch |-> gap == 16'(FINE_CYC - 1));
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_low_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !fine_latch |=> $stable(result[NIB_W-1:0]));
  p_valid_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc |=> !upper_valid);
  p_valid_at_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> upper_valid);
endmodule

bind twostep_flash_seq tsf_seq_chk #(.TRACK_CYC(TRACK_CYC), .FINE_CYC(FINE_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_acc(start_acc),
  .coarse_latch(coarse_latch), .fine_latch(fine_latch),
  .dac_code(dac_code_o), .result(result_o),
  .upper_valid(upper_valid_o), .done(done_o)
);

// File: tb/sim_twostep_flash_seq.sv
`timescale 1ns/1ps
module sim_twostep_flash_seq;
  localparam int TRK = 100;
  localparam int FIN = 60;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [14:0] coarse_therm_i = '0;
  logic [14:0] fine_therm_i = '0;
  logic [3:0]  dac_code_o;
  logic [7:0]  result_o;
  logic        upper_valid_o;
  logic        done_o;

  int   n_checks = 0;
  int   n_errors = 0;
  bit   finished = 1'b0;
  logic [7:0] exp_res = '0;
  logic [3:0] exp_dac = '0;

  always #2.5 clk = ~clk;

  twostep_flash_seq #(.TRACK_CYC(TRK), .FINE_CYC(FIN)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .coarse_therm_i(coarse_therm_i), .fine_therm_i(fine_therm_i),
    .dac_code_o(dac_code_o), .result_o(result_o),
    .upper_valid_o(upper_valid_o), .done_o(done_o)
  );

  // Reference encoder: scan from the top comparator down.
  function automatic logic [3:0] ref_code(input logic [14:0] t);
    for (int i = 14; i >= 0; i--) begin
      if (t[i]) return 4'(i + 1);
    end
    return 4'd0;
  endfunction

  function automatic logic [14:0] gen_therm();
    int n;
    if ($urandom_range(0, 1) == 0) begin
      n = $urandom_range(0, 15);
      return 15'((16'd1 << n) - 16'd1);
    end
    return 15'($urandom);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // One conversion; counts falling edges from the one that raises start.
  task automatic run_conv(input logic [14:0] c, input logic [14:0] f,
                          input bit poke, input bit chained, input bit chain_next);
    logic [3:0] uc;
    logic [3:0] lc;
    uc = ref_code(c);
    lc = ref_code(f);
    if (!chained) begin
      @(negedge clk);
      start_i = 1'b1;
    end
    for (int cyc = 1; cyc <= TRK + FIN + 1; cyc++) begin
      @(negedge clk);
      start_i        = poke && (cyc == TRK / 2 || cyc == TRK + FIN / 2);
      coarse_therm_i = (cyc == TRK) ? c : gen_therm();
      fine_therm_i   = (cyc == TRK + FIN) ? f : gen_therm();
      if (cyc == 1) begin
        chk(done_o == 1'b0, "R5 done width", done_o, 0);
        chk(upper_valid_o == 1'b0, "R8 valid cleared on start", upper_valid_o, 0);
      end
      if (cyc == TRK) begin
        chk(dac_code_o == exp_dac, "R4,R7 dac before coarse latch", dac_code_o, exp_dac);
        chk(upper_valid_o == 1'b0, "R3,R7 valid before coarse latch", upper_valid_o, 0);
      end
      if (cyc == TRK + 1) begin
        exp_dac = uc;
        exp_res = {uc, exp_res[3:0]};
        chk(dac_code_o == exp_dac, "R3,R9 dac code", dac_code_o, exp_dac);
        chk(result_o == exp_res, "R3,R6 result after coarse", result_o, exp_res);
        chk(upper_valid_o == 1'b1, "R8 valid high", upper_valid_o, 1);
      end
      if (cyc == TRK + FIN) begin
        chk(done_o == 1'b0, "R5,R7 no early done", done_o, 0);
        chk(result_o == exp_res, "R6 lower held", result_o, exp_res);
      end
      if (cyc == TRK + FIN + 1) begin
        exp_res = {uc, lc};
        chk(done_o == 1'b1, "R5 done pulse", done_o, 1);
        chk(result_o == exp_res, "R5,R2,R9 final result", result_o, exp_res);
        chk(dac_code_o == exp_dac, "R4 dac held", dac_code_o, exp_dac);
        start_i = chain_next;
      end
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(result_o == 8'd0, "R1 result reset", result_o, 0);
    chk(dac_code_o == 4'd0, "R1 dac reset", dac_code_o, 0);
    chk(upper_valid_o == 1'b0, "R1 valid reset", upper_valid_o, 0);
    chk(done_o == 1'b0, "R1 done reset", done_o, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // Directed corners: R2 extremes and bubbles.
    run_conv(15'h0000, 15'h7FFF, 1'b0, 1'b0, 1'b0);
    run_conv(15'h7FFF, 15'h0000, 1'b1, 1'b0, 1'b0);
    run_conv(15'b000_0000_0100_0111, 15'b100_0000_0000_0001, 1'b0, 1'b0, 1'b1);
    run_conv(15'h0001, 15'h00FF, 1'b1, 1'b1, 1'b0);

    begin
      bit ch = 1'b0;
      for (int k = 0; k < 20; k++) begin
        bit nx;
        nx = ($urandom_range(0, 2) == 0);
        run_conv(gen_therm(), gen_therm(), $urandom_range(0, 1) == 1, ch, nx);
        ch = nx;
      end
      if (ch) begin
        @(negedge clk);
        start_i = 1'b0;
        repeat (TRK + FIN + 4) @(negedge clk);
      end
    end
    repeat (3) @(negedge clk);
    chk(done_o == 1'b0, "R5 idle done low", done_o, 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule